// File: doc/BRIEF.md
# Wide-Line Direct-Mapped Second-Level Cache

This block is a unified second-level cache. It serves both the instruction and the data first-level caches through one 256-bit upper port, and it reaches main memory over a narrow 32-bit bus. Each upper transfer carries one complete 32-byte first-level line. A read returns that line. A write delivers a dirty line that the first level is evicting. Each second-level line holds 128 bytes, which is four such sub-blocks.

The cache is direct-mapped and write-back. A lookup costs a parameterised number of cycles, 3 by default. On a miss, the block first drains the victim line over the memory bus if the victim is dirty. It then fetches the new line in 32 single-word beats, starting at the word that opens the requested sub-block. A write that misses allocates the line first and then merges the incoming sub-block. Only one request is in flight at a time. A ready signal holds off the next request until the current response has been produced.

Top module: `l2w_cache`

## Requirements
- R1: While reset is asserted and after it is released, `up_ready` is 1, and both `up_rsp_valid` and `mem_valid` are 0.
- R2: A read that hits returns the cached 32-byte sub-block on `up_rsp_rdata`. Word k of the sub-block sits in bits 32k+31..32k. `up_rsp_valid` pulses for one cycle exactly HIT_LAT (default 3) cycles after the accepting clock edge, and the memory bus stays idle.
- R3: A write (an upper-level writeback) that hits replaces the addressed sub-block and is acknowledged by an `up_rsp_valid` pulse HIT_LAT cycles after acceptance, with no bus traffic. Later reads of that sub-block return the written data.
- R4: A miss fetches the line in 32 read beats. A beat completes when `mem_valid` and `mem_ready` are both high. Beat k uses address line_base + 4*((8*s + k) mod 32), where s = addr[6:5]. The response follows the last beat and carries the fetched data.
- R5: The line index is addr[10:7] (with 16 lines) and the tag is addr[31:11]. A request to the same index with another tag replaces the resident line, so the displaced address misses again.
- R6: A dirty victim is written back first as 32 write beats at victim_base + 4k, with k ascending, and all of them finish before the first fill beat. Afterwards memory holds the victim's current data.
- R7: An invalid or clean victim causes no write beats.
- R8: A write that misses fetches the whole line, merges the 256-bit sub-block and leaves the line dirty. Its other sub-blocks hold the memory data, and its later eviction writes back the merged data.
- R9: `up_ready` falls on the edge that accepts a request and stays low until the cycle of its response. Whenever `up_ready` is high, the memory bus is idle.
- R10: While `mem_valid` is high and `mem_ready` is low, `mem_addr`, `mem_write` and `mem_wdata` hold their values.
- R11: Address bits [4:0] of an upper request are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| up_req_valid | input | 1 | Upper request present |
| up_req_write | input | 1 | 1 = upper-level line writeback, 0 = read |
| up_req_addr | input | 32 | Byte address of the request |
| up_req_wdata | input | 256 | Sub-block written by a writeback |
| up_ready | output | 1 | Request accepted on the edge where valid and ready are both high |
| up_rsp_valid | output | 1 | One-cycle response or acknowledge pulse |
| up_rsp_rdata | output | 256 | Sub-block returned for a read |
| mem_valid | output | 1 | Memory beat requested |
| mem_write | output | 1 | 1 = write beat, 0 = read beat |
| mem_addr | output | 32 | Byte address of the beat's word |
| mem_wdata | output | 32 | Write-beat data |
| mem_ready | input | 1 | Beat completes on this edge when high together with `mem_valid` |
| mem_rdata | input | 32 | Read-beat data, valid while `mem_ready` is high |

## Verification
A hit response is due exactly HIT_LAT cycles after the accepting edge. The bench stamps each accepted request with the cycle count of that edge, and the monitor compares the cycle in which the pulse appears against that stamp. Miss responses depend on memory stalls, so they are checked for order and data only.

Bus beats are logged on the falling edge that precedes the completing rising edge. The beat count, the address order and the writeback-before-fill order are checked once the response has arrived, and nothing is sampled in between. Stall holding is checked on every falling edge that follows a stalled beat.

// File: rtl/l2w_pkg.sv
package l2w_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PROBE,
    ST_EVICT,
    ST_FETCH,
    ST_FINISH
  } l2w_state_e;
endpackage

// File: rtl/l2w_tag_store.sv
module l2w_tag_store #(
  parameter int NLINES = 16,
  parameter int TAGW   = 21,
  localparam int IDXW  = $clog2(NLINES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IDXW-1:0] lk_idx,
  output logic [TAGW-1:0] lk_tag,
  output logic            lk_valid,
  output logic            lk_dirty,
  input  logic            inst_en,
  input  logic [IDXW-1:0] inst_idx,
  input  logic [TAGW-1:0] inst_tag,
  input  logic            dset_en,
  input  logic [IDXW-1:0] dset_idx
);
  logic [NLINES-1:0] valid_q;
  logic [NLINES-1:0] dirty_q;
  logic [TAGW-1:0]   tag_q [NLINES];

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic inst_hit;
    logic dset_hit;
    assign inst_hit = inst_en && (inst_idx == IDXW'(g));
    assign dset_hit = dset_en && (dset_idx == IDXW'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        dirty_q[g] <= 1'b0;
      end else begin
        if (inst_hit) valid_q[g] <= 1'b1;
        if (inst_hit)      dirty_q[g] <= 1'b0;
        else if (dset_hit) dirty_q[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (inst_hit) tag_q[g] <= inst_tag;
    end
  end

  assign lk_tag   = tag_q[lk_idx];
  assign lk_valid = valid_q[lk_idx];
  assign lk_dirty = dirty_q[lk_idx];

  AST_NO_INSTALL_AND_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    !(inst_en && dset_en)); // R8
endmodule

// File: rtl/l2w_data_store.sv
module l2w_data_store #(
  parameter int ENTRIES = 64,
  parameter int SBW     = 256,
  parameter int MEMW    = 32,
  localparam int EW     = $clog2(ENTRIES),
  localparam int SELW   = $clog2(SBW / MEMW)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wd_en,
  input  logic [EW-1:0]   wd_entry,
  input  logic [SELW-1:0] wd_sel,
  input  logic [MEMW-1:0] wd_data,
  input  logic            sb_en,
  input  logic [EW-1:0]   sb_entry,
  input  logic [SBW-1:0]  sb_data,
  input  logic [EW-1:0]   rd_entry,
  output logic [SBW-1:0]  rd_data
);
  logic [SBW-1:0] arr [ENTRIES];

  always_ff @(posedge clk) begin
    if (wd_en) arr[wd_entry][wd_sel*MEMW +: MEMW] <= wd_data;
    if (sb_en) arr[sb_entry] <= sb_data;
  end

  assign rd_data = arr[rd_entry];

  AST_SINGLE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
    !(wd_en && sb_en)); // R8
endmodule

// File: rtl/l2w_ctrl.sv
module l2w_ctrl
  import l2w_pkg::*;
#(
  parameter int AW         = 32,
  parameter int NLINES     = 16,
  parameter int LAT        = 3,
  parameter int UPW        = 256,
  parameter int MEMW       = 32,
  parameter int LINE_BYTES = 128,
  localparam int SUBS  = LINE_BYTES / (UPW / 8),
  localparam int SUBW  = $clog2(SUBS),
  localparam int SELW  = $clog2(UPW / MEMW),
  localparam int WORDW = SUBW + SELW,
  localparam int BLW   = $clog2(MEMW / 8),
  localparam int OFFW  = $clog2(LINE_BYTES),
  localparam int IDXW  = $clog2(NLINES),
  localparam int TAGW  = AW - IDXW - OFFW,
  localparam int ENTW  = IDXW + SUBW,
  localparam int CNTW  = $clog2(LAT + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            up_req_valid,
  input  logic            up_req_write,
  input  logic [AW-1:0]   up_req_addr,
  input  logic [UPW-1:0]  up_req_wdata,
  output logic            up_ready,
  output logic            up_rsp_valid,
  output logic [UPW-1:0]  up_rsp_rdata,
  output logic            mem_valid,
  output logic            mem_write,
  output logic [AW-1:0]   mem_addr,
  output logic [MEMW-1:0] mem_wdata,
  input  logic            mem_ready,
  input  logic [MEMW-1:0] mem_rdata,
  output logic [IDXW-1:0] lk_idx,
  input  logic [TAGW-1:0] lk_tag,
  input  logic            lk_valid,
  input  logic            lk_dirty,
  output logic            inst_en,
  output logic [IDXW-1:0] inst_idx,
  output logic [TAGW-1:0] inst_tag,
  output logic            dset_en,
  output logic [IDXW-1:0] dset_idx,
  output logic            wd_en,
  output logic [ENTW-1:0] wd_entry,
  output logic [SELW-1:0] wd_sel,
  output logic [MEMW-1:0] wd_data,
  output logic            sb_en,
  output logic [ENTW-1:0] sb_entry,
  output logic [UPW-1:0]  sb_data,
  output logic [ENTW-1:0] rd_entry,
  input  logic [UPW-1:0]  rd_data
);
  localparam logic [WORDW-1:0] LASTB = WORDW'((1 << WORDW) - 1);

  l2w_state_e       st_q, st_d;
  logic [CNTW-1:0]  cnt_q, cnt_d;
  logic [WORDW-1:0] beat_q, beat_d;
  logic             rspv_q, rspv_d;

  logic             wr_q;
  logic [TAGW-1:0]  tag_q;
  logic [IDXW-1:0]  idx_q;
  logic [SUBW-1:0]  sub_q;
  logic [UPW-1:0]   data_q;
  logic [TAGW-1:0]  vtag_q;
  logic [UPW-1:0]   rsp_q;

  logic             req_ld;
  logic             vtag_ld;
  logic             rsp_ld;
  logic             hit;
  logic             probe_done;
  logic             evicting;
  logic             fetching;
  logic [WORDW-1:0] fword;

  // Fill order: start at the requested sub-block, wrap within the line.
  assign fword      = {sub_q, {SELW{1'b0}}} + beat_q;
  assign hit        = lk_valid && (lk_tag == tag_q);
  assign probe_done = (st_q == ST_PROBE) && (cnt_q == '0);
  assign evicting   = (st_q == ST_EVICT);
  assign fetching   = (st_q == ST_FETCH);
  assign req_ld     = (st_q == ST_IDLE) && up_req_valid;
  assign vtag_ld    = probe_done && !hit && lk_valid && lk_dirty;
  assign rsp_ld     = !wr_q && ((probe_done && hit) || (st_q == ST_FINISH));

  // Upper side
  assign up_ready     = (st_q == ST_IDLE);
  assign up_rsp_valid = rspv_q;
  assign up_rsp_rdata = rsp_q;

  // Lower side
  assign mem_valid = evicting || fetching;
  assign mem_write = evicting;
  assign mem_addr  = evicting ? {vtag_q, idx_q, beat_q, {BLW{1'b0}}}
                              : {tag_q, idx_q, fword, {BLW{1'b0}}};
  assign mem_wdata = rd_data[beat_q[SELW-1:0]*MEMW +: MEMW];

  // Tag store
  assign lk_idx   = idx_q;
  assign inst_idx = idx_q;
  assign inst_tag = tag_q;
  assign inst_en  = wd_en && (beat_q == LASTB);
  assign dset_idx = idx_q;
  assign dset_en  = sb_en;

  // Data store
  assign rd_entry = evicting ? {idx_q, beat_q[WORDW-1 -: SUBW]} : {idx_q, sub_q};
  assign wd_en    = fetching && mem_ready;
  assign wd_entry = {idx_q, fword[WORDW-1 -: SUBW]};
  assign wd_sel   = fword[SELW-1:0];
  assign wd_data  = mem_rdata;
  assign sb_en    = wr_q && ((probe_done && hit) || (st_q == ST_FINISH));
  assign sb_entry = {idx_q, sub_q};
  assign sb_data  = data_q;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    beat_d = beat_q;
    rspv_d = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (up_req_valid) begin
          cnt_d = CNTW'(LAT - 1);
          st_d  = ST_PROBE;
        end
      end
      ST_PROBE: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else if (hit) begin
          rspv_d = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          beat_d = '0;
          st_d   = (lk_valid && lk_dirty) ? ST_EVICT : ST_FETCH;
        end
      end
      ST_EVICT: begin
        if (mem_ready) begin
          beat_d = beat_q + 1'b1;
          if (beat_q == LASTB) st_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (mem_ready) begin
          beat_d = beat_q + 1'b1;
          if (beat_q == LASTB) st_d = ST_FINISH;
        end
      end
      ST_FINISH: begin
        rspv_d = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      beat_q <= '0;
      rspv_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      beat_q <= beat_d;
      rspv_q <= rspv_d;
    end
  end

  always_ff @(posedge clk) begin
    if (req_ld) begin
      wr_q   <= up_req_write;
      tag_q  <= up_req_addr[AW-1 -: TAGW];
      idx_q  <= up_req_addr[OFFW +: IDXW];
      sub_q  <= up_req_addr[OFFW-1 -: SUBW];
      data_q <= up_req_wdata;
    end
    if (vtag_ld) vtag_q <= lk_tag;
    if (rsp_ld)  rsp_q  <= rd_data;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNTW'(LAT - 1)); // R2
  AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    up_rsp_valid |=> !up_rsp_valid); // R2
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    up_req_valid && up_ready |=> !up_ready && !up_rsp_valid); // R9
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_wdata)); // R10
  AST_NO_WRITE_AFTER_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_write |=> !(mem_valid && mem_write)); // R6
endmodule

// File: rtl/l2w_cache.sv
module l2w_cache #(
  parameter int AW         = 32,
  parameter int NLINES     = 16,
  parameter int HIT_LAT    = 3,
  parameter int UPW        = 256,
  parameter int MEMW       = 32,
  parameter int LINE_BYTES = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            up_req_valid,
  input  logic            up_req_write,
  input  logic [AW-1:0]   up_req_addr,
  input  logic [UPW-1:0]  up_req_wdata,
  output logic            up_ready,
  output logic            up_rsp_valid,
  output logic [UPW-1:0]  up_rsp_rdata,
  output logic            mem_valid,
  output logic            mem_write,
  output logic [AW-1:0]   mem_addr,
  output logic [MEMW-1:0] mem_wdata,
  input  logic            mem_ready,
  input  logic [MEMW-1:0] mem_rdata
);
  localparam int SUBS = LINE_BYTES / (UPW / 8);
  localparam int SUBW = $clog2(SUBS);
  localparam int SELW = $clog2(UPW / MEMW);
  localparam int OFFW = $clog2(LINE_BYTES);
  localparam int IDXW = $clog2(NLINES);
  localparam int TAGW = AW - IDXW - OFFW;
  localparam int ENTW = IDXW + SUBW;

  logic [1:0] rst_sync_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  logic [IDXW-1:0] lk_idx;
  logic [TAGW-1:0] lk_tag;
  logic            lk_valid;
  logic            lk_dirty;
  logic            inst_en;
  logic [IDXW-1:0] inst_idx;
  logic [TAGW-1:0] inst_tag;
  logic            dset_en;
  logic [IDXW-1:0] dset_idx;
  logic            wd_en;
  logic [ENTW-1:0] wd_entry;
  logic [SELW-1:0] wd_sel;
  logic [MEMW-1:0] wd_data;
  logic            sb_en;
  logic [ENTW-1:0] sb_entry;
  logic [UPW-1:0]  sb_data;
  logic [ENTW-1:0] rd_entry;
  logic [UPW-1:0]  rd_data;

  l2w_ctrl #(
    .AW(AW), .NLINES(NLINES), .LAT(HIT_LAT), .UPW(UPW),
    .MEMW(MEMW), .LINE_BYTES(LINE_BYTES)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_sn),
    .up_req_valid(up_req_valid), .up_req_write(up_req_write),
    .up_req_addr(up_req_addr), .up_req_wdata(up_req_wdata),
    .up_ready(up_ready), .up_rsp_valid(up_rsp_valid), .up_rsp_rdata(up_rsp_rdata),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_valid(lk_valid), .lk_dirty(lk_dirty),
    .inst_en(inst_en), .inst_idx(inst_idx), .inst_tag(inst_tag),
    .dset_en(dset_en), .dset_idx(dset_idx),
    .wd_en(wd_en), .wd_entry(wd_entry), .wd_sel(wd_sel), .wd_data(wd_data),
    .sb_en(sb_en), .sb_entry(sb_entry), .sb_data(sb_data),
    .rd_entry(rd_entry), .rd_data(rd_data)
  );

  l2w_tag_store #(.NLINES(NLINES), .TAGW(TAGW)) u_tags (
    .clk(clk), .rst_n(rst_sn),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .lk_valid(lk_valid), .lk_dirty(lk_dirty),
    .inst_en(inst_en), .inst_idx(inst_idx), .inst_tag(inst_tag),
    .dset_en(dset_en), .dset_idx(dset_idx)
  );

  l2w_data_store #(.ENTRIES(NLINES * SUBS), .SBW(UPW), .MEMW(MEMW)) u_data (
    .clk(clk), .rst_n(rst_sn),
    .wd_en(wd_en), .wd_entry(wd_entry), .wd_sel(wd_sel), .wd_data(wd_data),
    .sb_en(sb_en), .sb_entry(sb_entry), .sb_data(sb_data),
    .rd_entry(rd_entry), .rd_data(rd_data)
  );
endmodule

// File: tb/tb_l2w_cache.sv
`timescale 1ns/1ps
module tb_l2w_cache;
  localparam int NL  = 16;
  localparam int LAT = 3;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         up_req_valid, up_req_write;
  logic [31:0]  up_req_addr;
  logic [255:0] up_req_wdata;
  logic         up_ready, up_rsp_valid;
  logic [255:0] up_rsp_rdata;
  logic         mem_valid, mem_write;
  logic [31:0]  mem_addr, mem_wdata;
  logic         mem_ready;
  logic [31:0]  mem_rdata;

  always #2 clk = ~clk;

  l2w_cache #(.NLINES(NL), .HIT_LAT(LAT)) dut (
    .clk(clk), .rst_n(rst_n),
    .up_req_valid(up_req_valid), .up_req_write(up_req_write),
    .up_req_addr(up_req_addr), .up_req_wdata(up_req_wdata),
    .up_ready(up_ready), .up_rsp_valid(up_rsp_valid), .up_rsp_rdata(up_rsp_rdata),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
  );

  int unsigned total = 0;
  int unsigned bad   = 0;
  int unsigned cyc   = 0;
  bit          finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string r, input logic [255:0] act, input logic [255:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", r, act, exp);
    end
  endtask

  // Memory behind the bus and the upper level's view of all data
  logic [31:0] mem_m [int unsigned];
  logic [31:0] ref_m [int unsigned];

  function automatic logic [31:0] dflt(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction
  function automatic logic [31:0] mem_rd(input logic [31:0] a);
    return mem_m.exists(a) ? mem_m[a] : dflt(a);
  endfunction
  function automatic logic [31:0] ref_rd(input logic [31:0] a);
    return ref_m.exists(a) ? ref_m[a] : dflt(a);
  endfunction

  // Bus beat log
  logic [31:0] log_addr [$];
  bit          log_wr   [$];

  int unsigned stall_ctr = 0;
  bit          prev_stall = 0;
  logic [31:0] prev_addr, prev_wd;
  bit          prev_wr;

  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready  = 1'b0;
      mem_rdata  = '0;
      prev_stall = 0;
    end else begin
      bit rdy;
      if (prev_stall)
        chk(mem_valid && mem_addr == prev_addr && mem_write == prev_wr && mem_wdata == prev_wd,
            "R10 beat held", {mem_write, mem_addr, mem_wdata}, {prev_wr, prev_addr, prev_wd});
      stall_ctr++;
      rdy       = (stall_ctr % 7) != 3 && (stall_ctr % 11) != 5;
      mem_ready = rdy;
      mem_rdata = mem_rd(mem_addr);
      if (mem_valid && rdy) begin
        log_addr.push_back(mem_addr);
        log_wr.push_back(mem_write);
        if (mem_write) mem_m[mem_addr] = mem_wdata;
      end
      prev_stall = mem_valid && !rdy;
      prev_addr  = mem_addr;
      prev_wr    = mem_write;
      prev_wd    = mem_wdata;
    end
  end

  // Scoreboard
  typedef struct {
    logic [255:0] data;
    bit           is_rd;
    bit           hit;
    int unsigned  acc;
    string        tag;
  } exp_t;
  exp_t sbq [$];

  always @(negedge clk) begin
    if (rst_n && up_rsp_valid) begin
      if (sbq.size() == 0) begin
        chk(0, "R9 unexpected response", 1, 0);
      end else begin
        exp_t e;
        e = sbq.pop_front();
        if (e.is_rd)
          chk(up_rsp_rdata == e.data, {e.tag, " read data"}, up_rsp_rdata, e.data);
        if (e.hit)
          chk(cyc - e.acc == LAT, {e.tag, " R2/R3 hit latency"}, 256'(cyc - e.acc), 256'(LAT));
      end
    end
  end

  // Bench view of the line state
  bit          bv [NL];
  bit          bd [NL];
  logic [20:0] bt [NL];

  task automatic access(input bit wr, input logic [31:0] a, input logic [255:0] wd, input string tag);
    int          idx;
    logic [20:0] tg;
    logic [31:0] lbase, sbase, vbase;
    int          s;
    bit          hit, vd;
    exp_t        e;
    int          nw, nr;
    bit          ok_w, ok_r, ok_o, ok_m;
    idx   = int'(a[10:7]);
    tg    = a[31:11];
    s     = int'(a[6:5]);
    lbase = {a[31:7], 7'b0};
    sbase = {a[31:5], 5'b0};
    hit   = bv[idx] && bt[idx] == tg;
    vd    = bv[idx] && !hit && bd[idx];
    vbase = {bt[idx], 4'(idx), 7'b0};
    e.is_rd = !wr;
    e.hit   = hit;
    e.tag   = tag;
    for (int k = 0; k < 8; k++) e.data[32*k +: 32] = ref_rd(sbase + 32'(4*k));
    if (wr) for (int k = 0; k < 8; k++) ref_m[sbase + 32'(4*k)] = wd[32*k +: 32];
    if (!hit) begin bv[idx] = 1; bt[idx] = tg; bd[idx] = 0; end
    if (wr) bd[idx] = 1;
    log_addr.delete();
    log_wr.delete();
    up_req_valid = 1'b1;
    up_req_write = wr;
    up_req_addr  = a;
    up_req_wdata = wd;
    while (!up_ready) @(negedge clk);
    e.acc = cyc + 1;
    sbq.push_back(e);
    @(negedge clk);
    up_req_valid = 1'b0;
    up_req_wdata = '0;
    chk(!up_ready, {tag, " R9 busy after accept"}, up_ready, 0);
    while (sbq.size() != 0) @(negedge clk);
    chk(up_ready && !mem_valid, {tag, " R9 idle after response"}, {up_ready, mem_valid}, 2'b10);
    nw = 0; nr = 0; ok_w = 1; ok_r = 1; ok_o = 1;
    foreach (log_addr[i]) begin
      if (log_wr[i]) begin
        if (nr != 0) ok_o = 0;
        if (log_addr[i] != vbase + 32'(4*nw)) ok_w = 0;
        nw++;
      end else begin
        if (log_addr[i] != lbase + 32'(4*((8*s + nr) % 32))) ok_r = 0;
        nr++;
      end
    end
    chk(nw == (vd ? 32 : 0), {tag, vd ? " R6 write beats" : " R7 no write beats"}, 256'(nw), 256'(vd ? 32 : 0));
    chk(nr == (hit ? 0 : 32), {tag, " R4 read beat count"}, 256'(nr), 256'(hit ? 0 : 32));
    if (!hit) chk(ok_r, {tag, " R4 fill order"}, ok_r, 1);
    if (vd) begin
      ok_m = 1;
      for (int k = 0; k < 32; k++)
        if (mem_rd(vbase + 32'(4*k)) != ref_rd(vbase + 32'(4*k))) ok_m = 0;
      chk(ok_w && ok_o && ok_m, {tag, " R6 victim order/data"}, {ok_w, ok_o, ok_m}, 3'b111);
    end
  endtask

  function automatic logic [255:0] pat(input logic [31:0] seed);
    logic [255:0] p;
    for (int k = 0; k < 8; k++) p[32*k +: 32] = seed ^ (32'h01010101 * 32'(k + 1));
    return p;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog expired", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NL; i++) begin bv[i] = 0; bd[i] = 0; bt[i] = '0; end
    rst_n = 1'b0;
    up_req_valid = 1'b0; up_req_write = 1'b0; up_req_addr = '0; up_req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(up_ready && !up_rsp_valid && !mem_valid, "R1 during reset", {up_ready, up_rsp_valid, mem_valid}, 3'b100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(up_ready && !up_rsp_valid && !mem_valid, "R1 after reset", {up_ready, up_rsp_valid, mem_valid}, 3'b100);

    access(0, 32'h0000_1040, '0, "R4 cold miss");
    access(0, 32'h0000_1060, '0, "R2 read hit");
    access(0, 32'h0000_1047, '0, "R11 low bits ignored");
    access(1, 32'h0000_1000, pat(32'hCAFE0000), "R3 write hit");
    access(0, 32'h0000_1000, '0, "R3 read back");
    access(0, 32'h0000_1800, '0, "R5 conflict dirty victim");
    access(0, 32'h0000_1000, '0, "R5 displaced line misses");
    access(1, 32'h0000_2264, pat(32'hBEEF0000), "R8 write miss");
    access(0, 32'h0000_2260, '0, "R8 merged sub-block");
    access(0, 32'h0000_2240, '0, "R8 fetched sub-block");
    access(0, 32'h0000_2A00, '0, "R8 merged line evicted");

    for (int n = 0; n < 60; n++) begin
      logic [31:0] a;
      bit          w;
      a = {19'(($urandom % 3) + 1), 2'b0, 4'($urandom % 4), 2'($urandom % 4), 5'($urandom % 32)};
      w = ($urandom % 3) == 0;
      access(w, a, pat($urandom), w ? "R3 mixed write" : "R2 mixed read");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule